// File: doc/BRIEF.md
# Fifth-Order Fixed-Point Highpass IIR Cascade

This block is a fifth-order Butterworth highpass filter for a 48 kHz sample stream with its corner at 10.8 kHz. It is built as three sections in series: a biquad, a second biquad, and a first-order section. All arithmetic is fixed point. One sample enters on each clock cycle in which the enable input is high.

Each section is a direct-form-I recursion with a wide accumulator. Its sum of products is floored by 14 bits and clamped to 16 bits before it feeds the next section. Coefficients are parameters in signed Q2.14. A register captures the input sample. Section 3 reads the output history of section 2, so the chain has a fixed delay of two samples. The output comes straight from section 3's combinational logic, with no register on the port.

Top module: `hp_iir5`

## Requirements
- R1: Each section computes y[n] = b0·x[n] + b1·x[n-1] (+ b2·x[n-2]) − a1·y[n-1] (− a2·y[n-2]), with signed 16-bit Q2.14 coefficients. Sections run in the order biquad 1, biquad 2, first-order 3, and the output is bit-exact to that cascade. A constant input settles to an output within ±8 of zero after 200 samples.
- R2: A register captures the input. The value on dout after the e-th enabled clock edge is the cascade response to the sample presented at the (e−1)-th enabled edge, counting from 1. An impulse of 8192 after reset therefore yields 0, then 628.
- R3: Every section rescales its accumulator by an arithmetic right shift of 14, which rounds toward negative infinity. An impulse of −8192 after reset yields 0, then −630.
- R4: Every section result that is out of range clamps to 32767 or −32768 and does not wrap. A full-scale alternating input of 32767/−32768 drives dout to a rail.
- R5: While en is low, no register changes, din is ignored and dout holds its value. Filtering resumes as if the disabled cycles never happened.
- R6: rst is active high and asynchronous. It clears all state to zero, so dout reads 0 at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| en | input | 1 | Sample enable; low freezes all state |
| din | input | DW (16) | Signed input sample |
| dout | output | DW (16) | Signed filtered sample, combinational from state |

## Verification
The hardest case to reach is saturation inside a section. Clamping changes the recursion state, and it only shows when a large signal lands near the top of the passband. The stimulus gets there with a full-scale alternating sequence at the Nyquist rate that starts abruptly from rest. The filter's step overshoot then pushes the sections past the rails, and a bit-exact model follows the clamped state from that point on. Enable gaps carrying a garbage din value are placed inside chirp and ramp runs to show that a frozen cycle leaves no mark.

// File: rtl/hp_iir5.sv
module hp_iir5 #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter logic signed [CW-1:0] S1_B0 = CW'(5266),
  parameter logic signed [CW-1:0] S1_B1 = CW'(-10532),
  parameter logic signed [CW-1:0] S1_B2 = CW'(5266),
  parameter logic signed [CW-1:0] S1_A1 = CW'(-2849),
  parameter logic signed [CW-1:0] S1_A2 = CW'(1830),
  parameter logic signed [CW-1:0] S2_B0 = CW'(7258),
  parameter logic signed [CW-1:0] S2_B1 = CW'(-14516),
  parameter logic signed [CW-1:0] S2_B2 = CW'(7258),
  parameter logic signed [CW-1:0] S2_A1 = CW'(-3927),
  parameter logic signed [CW-1:0] S2_A2 = CW'(8721),
  parameter logic signed [CW-1:0] S3_B0 = CW'(8836),
  parameter logic signed [CW-1:0] S3_B1 = CW'(-8836),
  parameter logic signed [CW-1:0] S3_A1 = CW'(-1289)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);

  localparam int AW = DW + CW + 3;

  function automatic logic signed [AW-1:0] xd(input logic signed [DW-1:0] v);
    return {{(AW-DW){v[DW-1]}}, v};
  endfunction

  function automatic logic signed [AW-1:0] xc(input logic signed [CW-1:0] v);
    return {{(AW-CW){v[CW-1]}}, v};
  endfunction

  function automatic logic signed [DW-1:0] fsat(input logic signed [AW-1:0] acc);
    logic signed [AW-1:0] sh;
    sh = acc >>> FRAC;
    if ((&sh[AW-1:DW-1]) || !(|sh[AW-1:DW-1]))
      return sh[DW-1:0];
    return sh[AW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
  endfunction

  // input register and section-1 input history
  logic signed [DW-1:0] x_q, x_d1, x_d2;
  // output histories; section 2's feed section 3 as its input history
  logic signed [DW-1:0] u_d1, u_d2, v_d1, v_d2, w_d1;
  logic signed [AW-1:0] acc1, acc2, acc3;
  logic signed [DW-1:0] u, v;

  assign acc1 = xc(S1_B0) * xd(x_q)  + xc(S1_B1) * xd(x_d1) + xc(S1_B2) * xd(x_d2)
              - xc(S1_A1) * xd(u_d1) - xc(S1_A2) * xd(u_d2);
  assign u    = fsat(acc1);

  assign acc2 = xc(S2_B0) * xd(u)    + xc(S2_B1) * xd(u_d1) + xc(S2_B2) * xd(u_d2)
              - xc(S2_A1) * xd(v_d1) - xc(S2_A2) * xd(v_d2);
  assign v    = fsat(acc2);

  assign acc3 = xc(S3_B0) * xd(v_d1) + xc(S3_B1) * xd(v_d2) - xc(S3_A1) * xd(w_d1);
  assign dout = fsat(acc3);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      x_q  <= '0;
      x_d1 <= '0;
      x_d2 <= '0;
      u_d1 <= '0;
      u_d2 <= '0;
      v_d1 <= '0;
      v_d2 <= '0;
      w_d1 <= '0;
    end else if (en) begin
      x_q  <= din;
      x_d1 <= x_q;
      x_d2 <= x_d1;
      u_d1 <= u;
      u_d2 <= u_d1;
      v_d1 <= v;
      v_d2 <= v_d1;
      w_d1 <= dout;
    end
  end

  a_r2_input_capture: assert property (@(posedge clk) disable iff (rst)
    en |=> x_q == $past(din));

  a_r2_mid_stage: assert property (@(posedge clk) disable iff (rst)
    en |=> v_d1 == $past(v));

  a_r5_output_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout));

  a_r5_state_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable({x_q, x_d1, x_d2, u_d1, u_d2, v_d1, v_d2, w_d1}));

  a_r6_reset_clear: assert property (@(posedge clk)
    rst |-> (dout == '0 && x_q == '0));

endmodule

// File: tb/hp_iir5_test.sv
module hp_iir5_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, en;
  logic signed [15:0] din;
  wire  signed [15:0] dout;

  hp_iir5 uut (.clk(clk), .rst(rst), .en(en), .din(din), .dout(dout));

  int total = 0, bad = 0;
  bit done = 0, rail = 0;

  // kind (0 step, 1 sawtooth, 2 chirp, 3 nyquist), amplitude/slope, length, enable gaps
  localparam int NSEG = 6;
  localparam int SEG [NSEG][4] = '{
    '{0, 12000, 200, 0},
    '{1,   173, 300, 0},
    '{2, 20000, 600, 0},
    '{3, 32767,  60, 0},
    '{2, 15000, 300, 1},
    '{1,   211, 200, 1}
  };

  // bench coefficients, Q2.14
  localparam longint B10 = 5266, B11 = -10532, B12 = 5266, A11 = -2849, A12 = 1830;
  localparam longint B20 = 7258, B21 = -14516, B22 = 7258, A21 = -3927, A22 = 8721;
  localparam longint B30 = 8836, B31 = -8836,  A31 = -1289;

  longint p1x1, p1x2, p1y1, p1y2, p2x1, p2x2, p2y1, p2y2, p3x1, p3y1;
  int mprev, mexp;

  function automatic longint qs(longint acc);
    longint s;
    s = acc >>> 14;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic mreset();
    p1x1 = 0; p1x2 = 0; p1y1 = 0; p1y2 = 0;
    p2x1 = 0; p2x2 = 0; p2y1 = 0; p2y2 = 0;
    p3x1 = 0; p3y1 = 0;
    mprev = 0; mexp = 0;
  endtask

  task automatic mstep(int d);
    longint x, a, b, c;
    x = d;
    a = qs(B10*x + B11*p1x1 + B12*p1x2 - A11*p1y1 - A12*p1y2);
    p1x2 = p1x1; p1x1 = x; p1y2 = p1y1; p1y1 = a;
    b = qs(B20*a + B21*p2x1 + B22*p2x2 - A21*p2y1 - A22*p2y2);
    p2x2 = p2x1; p2x1 = a; p2y2 = p2y1; p2y1 = b;
    c = qs(B30*b + B31*p3x1 - A31*p3y1);
    p3x1 = b; p3y1 = c;
    mexp = mprev;
    mprev = int'(c);
  endtask

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cyc(string req, bit e, int d);
    en = e;
    din = 16'(d);
    if (e) mstep(d);
    @(negedge clk);
    if (dout == 16'sd32767 || dout == -16'sd32768) rail = 1;
    check(req, int'(dout), mexp);
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0; din = '0;
    mreset();
    #1 check("R6 reset clears", int'(dout), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int stim(int kind, int amp, int len, int k);
    case (kind)
      0: return amp;
      1: return ((k * amp) % 60000) - 30000;
      2: return $rtoi(amp * $sin(3.14159265358979 * k * k / (2.0 * len)));
      default: return (k % 2) ? -32768 : 32767;
    endcase
  endfunction

  initial begin
    rst = 1'b1; en = 1'b0; din = '0;
    mreset();
    repeat (2) @(negedge clk);
    check("R6 reset state", int'(dout), 0);
    rst = 1'b0;

    // R2 latency with a positive impulse
    cyc("R2", 1'b1, 8192);
    check("R2 first output", int'(dout), 0);
    cyc("R2", 1'b1, 0);
    check("R2 impulse response", int'(dout), 628);
    for (int i = 0; i < 20; i++) cyc("R2", 1'b1, 0);

    // R3 floor rounding on a negative impulse
    @(negedge clk);
    do_reset();
    cyc("R3", 1'b1, -8192);
    cyc("R3", 1'b1, 0);
    check("R3 floor impulse", int'(dout), -630);
    for (int i = 0; i < 20; i++) cyc("R3", 1'b1, 0);

    @(negedge clk);
    do_reset();
    for (int s = 0; s < NSEG; s++) begin
      string req;
      req = (SEG[s][3] != 0) ? "R5" : (SEG[s][0] == 3) ? "R4" : (SEG[s][0] == 1) ? "R3" : "R1";
      rail = 0;
      for (int k = 0; k < SEG[s][2]; k++) begin
        bit e;
        e = (SEG[s][3] != 0) ? ((k % 3) != 2) : 1'b1;
        cyc(req, e, e ? stim(SEG[s][0], SEG[s][1], SEG[s][2], k) : 12345);
      end
      if (s == 0) check("R1 dc rejection", (dout <= 16'sd8 && dout >= -16'sd8) ? 1 : 0, 1);
      if (s == 3) check("R4 rail reached", int'(rail), 1);
    end

    // R6 asynchronous reset between edges
    for (int k = 0; k < 10; k++) cyc("R6", 1'b1, 9000 - k * 1500);
    #2 rst = 1'b1;
    #1 check("R6 async clear", int'(dout), 0);
    @(negedge clk);
    rst = 1'b0;
    mreset();
    for (int k = 0; k < 50; k++) cyc("R6", 1'b1, 5000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule